// File: doc/BRIEF.md
# Dual-Mode Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a processor that keeps user and supervisor address spaces apart. It holds two independent direct-mapped entry sets, one per privilege mode. A lookup presents a virtual page number and a mode flag. In the same cycle it returns hit, the physical frame number and two protection bits (read-only and cache-inhibit). On a miss, an external table walker supplies a refill that replaces the slot the page number indexes.

A small register file sits beside the buffer. It holds the user and supervisor segment table pointers, a flush-control register and a command/status register. Invalidation is triggered purely by side effects of register traffic. Reading the flush-control register empties both sets. The value written to it picks which set is emptied. Rewriting either table pointer empties that mode's set. A separate purge port removes one page's translation from both sets. The command/status register carries per-mode translation enables (pass-through when off), three plain control outputs, and four sticky fault flags.

Top module: `mmu_xlat_tlb`

## Requirements
- R1: User and supervisor translations are held apart; a lookup with `lk_super`=1 sees only supervisor refills and with `lk_super`=0 only user refills.
- R2: With translation enabled, a lookup hits in the same cycle when the mode's set holds the page, returning the refilled frame and protection (`lk_prot` bit 1 cache-inhibit, bit 0 read-only); a refill takes effect from the next cycle and replaces the slot selected by the low log2(DEPTH) bits of the page number, evicting any other page sharing that slot.
- R3: A read of the flush-control register (`reg_sel`=2) returns 0 and invalidates every entry in both sets.
- R4: A write of 0 to the flush-control register invalidates only the user set; a write of 32'h0000_8000 invalidates only the supervisor set; any other written value leaves both sets unchanged.
- R5: A write to the supervisor pointer (`reg_sel`=0) or user pointer (`reg_sel`=1) stores the low PN_W bits of the data, which read back and drive `sup_ptr`/`usr_ptr`, and invalidates that mode's set.
- R6: A purge of a page number removes that page's translation from both sets and leaves every other entry, including a different page in the same slot, intact.
- R7: Command/status bits 15, 14, 13 and 3 are set by `flt_ptab`, `flt_page`, `flt_prot` and `flt_bus` respectively, stay set, and clear only when a command/status write has a 1 in that bit position; a set in the same cycle as a clear leaves the bit set.
- R8: Command/status bit 0 enables user translation and bit 1 supervisor translation; with a mode disabled its lookups report hit, return the page number unchanged as the frame, and return protection 0.
- R9: Command/status bits 2, 5 and 6 are read/write and drive `ext_cache_en`, `icache_en` and `copro_en`.
- R10: When an invalidation (whole-set flush of the refill's mode, or a purge of the refill's own page) coincides with a refill, the refill is discarded.
- R11: After reset all entries are invalid and all registers, including the command/status register, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lk_vpn | input | PN_W | Lookup virtual page number |
| lk_super | input | 1 | Lookup mode, 1 = supervisor |
| lk_hit | output | 1 | Lookup hit (or pass-through) |
| lk_pfn | output | PN_W | Translated frame number |
| lk_prot | output | 2 | {cache-inhibit, read-only} |
| rf_valid | input | 1 | Refill strobe |
| rf_super | input | 1 | Refill target mode |
| rf_vpn | input | PN_W | Refill page number |
| rf_pfn | input | PN_W | Refill frame number |
| rf_prot | input | 2 | Refill protection bits |
| pg_valid | input | 1 | Purge strobe |
| pg_vpn | input | PN_W | Page number to purge |
| reg_sel | input | 2 | 0 sup pointer, 1 user pointer, 2 flush control, 3 command/status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| flt_ptab | input | 1 | Page-table fault event |
| flt_page | input | 1 | Page fault event |
| flt_prot | input | 1 | Protection fault event |
| flt_bus | input | 1 | MMU bus-error event |
| sup_ptr | output | PN_W | Supervisor segment table pointer |
| usr_ptr | output | PN_W | User segment table pointer |
| ext_cache_en | output | 1 | External cache enable |
| icache_en | output | 1 | Instruction cache enable |
| copro_en | output | 1 | Coprocessor enable |

## Verification
The hardest situations to reach are collisions inside one cycle: a refill landing together with a flush of its own mode, with a purge of its own page, or with a purge of a different page that shares its slot, and a fault event arriving in the same cycle software clears that flag. The bench drives these strobes together on one clock deliberately and follows each with lookups of both pages in both modes. A behavioural model keyed by mode and page number predicts every lookup, read and control output on each cycle.

// File: rtl/mmu_xlat_pkg.sv
package mmu_xlat_pkg;

  typedef enum logic [1:0] {
    SEL_SUP_PTR  = 2'd0,
    SEL_USR_PTR  = 2'd1,
    SEL_FLUSH    = 2'd2,
    SEL_CMD_STAT = 2'd3
  } reg_sel_e;

  localparam int CS_USR_EN  = 0;
  localparam int CS_SUP_EN  = 1;
  localparam int CS_ECACHE  = 2;
  localparam int CS_BUSERR  = 3;
  localparam int CS_ICACHE  = 5;
  localparam int CS_COPRO   = 6;
  localparam int CS_PROTF   = 13;
  localparam int CS_PAGEF   = 14;
  localparam int CS_PTABF   = 15;

  localparam logic [31:0] FLUSH_USR_CODE = 32'h0000_0000;
  localparam logic [31:0] FLUSH_SUP_CODE = 32'h0000_8000;

  // {cache inhibit, read only}
  typedef struct packed {
    logic ci;
    logic ro;
  } prot_t;

  function automatic logic is_usr_flush_code(input logic [31:0] v);
    return v == FLUSH_USR_CODE;
  endfunction

  function automatic logic is_sup_flush_code(input logic [31:0] v);
    return v == FLUSH_SUP_CODE;
  endfunction

endpackage

// File: rtl/mmu_xlat_bank.sv
module mmu_xlat_bank
  import mmu_xlat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PN_W  = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PN_W-1:0] lk_vpn,
  output logic            lk_hit,
  output logic [PN_W-1:0] lk_pfn,
  output prot_t           lk_prot,
  input  logic            flush,
  input  logic            pg_valid,
  input  logic [PN_W-1:0] pg_vpn,
  input  logic            fill_valid,
  input  logic [PN_W-1:0] fill_vpn,
  input  logic [PN_W-1:0] fill_pfn,
  input  prot_t           fill_prot
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = PN_W - IDX_W;

  function automatic logic [IDX_W-1:0] slot_of(input logic [PN_W-1:0] vpn);
    return vpn[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PN_W-1:0] vpn);
    return vpn[PN_W-1:IDX_W];
  endfunction

  logic [DEPTH-1:0] v_q;
  logic [TAG_W-1:0] tag_q  [DEPTH];
  logic [PN_W-1:0]  pfn_q  [DEPTH];
  prot_t            prot_q [DEPTH];

  logic [IDX_W-1:0] lk_idx, pg_idx, fill_idx;
  logic             purge_hit;
  logic             fill_ok;
  logic             fill_killed;

  assign lk_idx   = slot_of(lk_vpn);
  assign pg_idx   = slot_of(pg_vpn);
  assign fill_idx = slot_of(fill_vpn);

  assign purge_hit   = pg_valid && v_q[pg_idx] && (tag_q[pg_idx] == tag_of(pg_vpn));
  assign fill_killed = flush || (pg_valid && (pg_vpn == fill_vpn));
  assign fill_ok     = fill_valid && !fill_killed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else if (flush) begin
      v_q <= '0;
    end else begin
      if (purge_hit) v_q[pg_idx]   <= 1'b0;
      if (fill_ok)   v_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_ok) begin
      tag_q[fill_idx]  <= tag_of(fill_vpn);
      pfn_q[fill_idx]  <= fill_pfn;
      prot_q[fill_idx] <= fill_prot;
    end
  end

  assign lk_hit  = v_q[lk_idx] && (tag_q[lk_idx] == tag_of(lk_vpn));
  assign lk_pfn  = pfn_q[lk_idx];
  assign lk_prot = prot_q[lk_idx];

  // R3 R4 R5
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (v_q == '0));

  // R6
  purge_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (purge_hit && !(fill_ok && (fill_idx == pg_idx))) |=> !v_q[$past(pg_idx)]);

  // R10
  inval_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_killed && !(pg_valid && !flush && (pg_idx != fill_idx) && v_q[fill_idx]))
      |=> !(v_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(tag_of(fill_vpn)))) || !$past(flush) && $past(v_q[fill_idx]) && ($past(tag_q[fill_idx]) != $past(tag_of(fill_vpn))) || (v_q == '0));

  // R2
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |=> (v_q[$past(fill_idx)] && (tag_q[$past(fill_idx)] == $past(tag_of(fill_vpn)))));

endmodule

// File: rtl/mmu_xlat_regs.sv
module mmu_xlat_regs
  import mmu_xlat_pkg::*;
#(
  parameter int PN_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            flt_ptab,
  input  logic            flt_page,
  input  logic            flt_prot,
  input  logic            flt_bus,
  output logic [PN_W-1:0] sup_ptr,
  output logic [PN_W-1:0] usr_ptr,
  output logic            usr_xl_en,
  output logic            sup_xl_en,
  output logic            ext_cache_en,
  output logic            icache_en,
  output logic            copro_en,
  output logic            flush_usr,
  output logic            flush_sup
);
  logic sptr_wr, uptr_wr, fl_wr, fl_rd, cs_wr;
  logic ptab_q, page_q, protf_q, bus_q;
  logic [15:0] cs_view;

  assign sptr_wr = reg_wr && (reg_sel == SEL_SUP_PTR);
  assign uptr_wr = reg_wr && (reg_sel == SEL_USR_PTR);
  assign fl_wr   = reg_wr && (reg_sel == SEL_FLUSH);
  assign fl_rd   = reg_rd && (reg_sel == SEL_FLUSH);
  assign cs_wr   = reg_wr && (reg_sel == SEL_CMD_STAT);

  assign flush_usr = uptr_wr || fl_rd || (fl_wr && is_usr_flush_code(reg_wdata));
  assign flush_sup = sptr_wr || fl_rd || (fl_wr && is_sup_flush_code(reg_wdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_ptr <= '0;
      usr_ptr <= '0;
    end else begin
      if (sptr_wr) sup_ptr <= reg_wdata[PN_W-1:0];
      if (uptr_wr) usr_ptr <= reg_wdata[PN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_xl_en    <= 1'b0;
      sup_xl_en    <= 1'b0;
      ext_cache_en <= 1'b0;
      icache_en    <= 1'b0;
      copro_en     <= 1'b0;
    end else if (cs_wr) begin
      usr_xl_en    <= reg_wdata[CS_USR_EN];
      sup_xl_en    <= reg_wdata[CS_SUP_EN];
      ext_cache_en <= reg_wdata[CS_ECACHE];
      icache_en    <= reg_wdata[CS_ICACHE];
      copro_en     <= reg_wdata[CS_COPRO];
    end
  end

  // sticky flags: write-one-to-clear, a new event wins over a clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptab_q  <= 1'b0;
      page_q  <= 1'b0;
      protf_q <= 1'b0;
      bus_q   <= 1'b0;
    end else begin
      ptab_q  <= flt_ptab || (ptab_q  && !(cs_wr && reg_wdata[CS_PTABF]));
      page_q  <= flt_page || (page_q  && !(cs_wr && reg_wdata[CS_PAGEF]));
      protf_q <= flt_prot || (protf_q && !(cs_wr && reg_wdata[CS_PROTF]));
      bus_q   <= flt_bus  || (bus_q   && !(cs_wr && reg_wdata[CS_BUSERR]));
    end
  end

  always_comb begin
    cs_view            = '0;
    cs_view[CS_USR_EN] = usr_xl_en;
    cs_view[CS_SUP_EN] = sup_xl_en;
    cs_view[CS_ECACHE] = ext_cache_en;
    cs_view[CS_BUSERR] = bus_q;
    cs_view[CS_ICACHE] = icache_en;
    cs_view[CS_COPRO]  = copro_en;
    cs_view[CS_PROTF]  = protf_q;
    cs_view[CS_PAGEF]  = page_q;
    cs_view[CS_PTABF]  = ptab_q;
  end

  always_comb begin
    case (reg_sel)
      SEL_SUP_PTR:  reg_rdata = 32'(sup_ptr);
      SEL_USR_PTR:  reg_rdata = 32'(usr_ptr);
      SEL_FLUSH:    reg_rdata = 32'h0;
      default:      reg_rdata = 32'(cs_view);
    endcase
  end

  // R7
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_wr |=> ((cs_view & 16'hE008 & $past(cs_view)) == ($past(cs_view) & 16'hE008)));

  // R7
  fault_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_page |=> page_q);

  // R5
  ptr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uptr_wr |=> (usr_ptr == $past(reg_wdata[PN_W-1:0])));

endmodule

// File: rtl/mmu_xlat_tlb.sv
module mmu_xlat_tlb
  import mmu_xlat_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PN_W  = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PN_W-1:0] lk_vpn,
  input  logic            lk_super,
  output logic            lk_hit,
  output logic [PN_W-1:0] lk_pfn,
  output logic [1:0]      lk_prot,
  input  logic            rf_valid,
  input  logic            rf_super,
  input  logic [PN_W-1:0] rf_vpn,
  input  logic [PN_W-1:0] rf_pfn,
  input  logic [1:0]      rf_prot,
  input  logic            pg_valid,
  input  logic [PN_W-1:0] pg_vpn,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            flt_ptab,
  input  logic            flt_page,
  input  logic            flt_prot,
  input  logic            flt_bus,
  output logic [PN_W-1:0] sup_ptr,
  output logic [PN_W-1:0] usr_ptr,
  output logic            ext_cache_en,
  output logic            icache_en,
  output logic            copro_en
);
  localparam int NMODE = 2;

  logic usr_xl_en, sup_xl_en, flush_usr, flush_sup;
  logic            bank_hit  [NMODE];
  logic [PN_W-1:0] bank_pfn  [NMODE];
  prot_t           bank_prot [NMODE];
  logic            mode_en;

  mmu_xlat_regs #(.PN_W(PN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flt_ptab(flt_ptab), .flt_page(flt_page), .flt_prot(flt_prot), .flt_bus(flt_bus),
    .sup_ptr(sup_ptr), .usr_ptr(usr_ptr),
    .usr_xl_en(usr_xl_en), .sup_xl_en(sup_xl_en),
    .ext_cache_en(ext_cache_en), .icache_en(icache_en), .copro_en(copro_en),
    .flush_usr(flush_usr), .flush_sup(flush_sup)
  );

  // bank 0 serves user mode, bank 1 supervisor mode
  for (genvar g = 0; g < NMODE; g++) begin : g_bank
    localparam logic IS_SUP = (g == 1);
    logic  bank_flush, bank_fill;
    prot_t fill_p;
    assign bank_flush = IS_SUP ? flush_sup : flush_usr;
    assign bank_fill  = rf_valid && (rf_super == IS_SUP);
    assign fill_p     = prot_t'(rf_prot);

    mmu_xlat_bank #(.DEPTH(DEPTH), .PN_W(PN_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_hit(bank_hit[g]), .lk_pfn(bank_pfn[g]), .lk_prot(bank_prot[g]),
      .flush(bank_flush), .pg_valid(pg_valid), .pg_vpn(pg_vpn),
      .fill_valid(bank_fill), .fill_vpn(rf_vpn), .fill_pfn(rf_pfn), .fill_prot(fill_p)
    );
  end

  assign mode_en = lk_super ? sup_xl_en : usr_xl_en;

  always_comb begin
    if (!mode_en) begin
      lk_hit  = 1'b1;
      lk_pfn  = lk_vpn;
      lk_prot = 2'b00;
    end else begin
      lk_hit  = bank_hit[lk_super];
      lk_pfn  = bank_pfn[lk_super];
      lk_prot = bank_prot[lk_super];
    end
  end

  // R8
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en) |-> (lk_hit && (lk_pfn == lk_vpn) && (lk_prot == 2'b00)));

  // R1
  mode_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_en && lk_hit) |-> bank_hit[lk_super]);

endmodule

// File: tb/mmu_xlat_tlb_bench.sv
`timescale 1ns/1ps
module mmu_xlat_tlb_bench;
  localparam int DEPTH = 16;
  localparam int PN_W  = 20;
  localparam logic [15:0] CMASK = 16'h0067;
  localparam logic [15:0] FMASK = 16'hE008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [PN_W-1:0] lk_vpn = '0;
  logic            lk_super = 1'b0;
  logic            lk_hit;
  logic [PN_W-1:0] lk_pfn;
  logic [1:0]      lk_prot;
  logic            rf_valid = 1'b0, rf_super = 1'b0;
  logic [PN_W-1:0] rf_vpn = '0, rf_pfn = '0;
  logic [1:0]      rf_prot = '0;
  logic            pg_valid = 1'b0;
  logic [PN_W-1:0] pg_vpn = '0;
  logic [1:0]      reg_sel = '0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic            flt_ptab = 0, flt_page = 0, flt_prot = 0, flt_bus = 0;
  logic [PN_W-1:0] sup_ptr, usr_ptr;
  logic            ext_cache_en, icache_en, copro_en;

  mmu_xlat_tlb #(.DEPTH(DEPTH), .PN_W(PN_W)) u_mmu_xlat_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(lk_vpn), .lk_super(lk_super), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_prot(lk_prot),
    .rf_valid(rf_valid), .rf_super(rf_super), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_prot(rf_prot),
    .pg_valid(pg_valid), .pg_vpn(pg_vpn),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flt_ptab(flt_ptab), .flt_page(flt_page), .flt_prot(flt_prot), .flt_bus(flt_bus),
    .sup_ptr(sup_ptr), .usr_ptr(usr_ptr),
    .ext_cache_en(ext_cache_en), .icache_en(icache_en), .copro_en(copro_en)
  );

  int total = 0;
  int bad = 0;

  // reference state: translations keyed by mode and page number
  logic [21:0]     mdl [int];
  logic [PN_W-1:0] m_sptr = '0, m_uptr = '0;
  logic [15:0]     m_cs = '0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int key_of(input logic s, input logic [PN_W-1:0] vpn);
    return (s ? (1 << PN_W) : 0) + int'(vpn);
  endfunction

  function automatic logic [31:0] exp_rdata();
    case (reg_sel)
      2'd0: return 32'(m_sptr);
      2'd1: return 32'(m_uptr);
      2'd2: return 32'h0;
      default: return 32'(m_cs);
    endcase
  endfunction

  task automatic compare(input string req);
    logic en;
    int k;
    en = lk_super ? m_cs[1] : m_cs[0];
    if (!en) begin
      chk(req, "passthru hit", 32'(lk_hit), 32'd1);
      chk(req, "passthru pfn", 32'(lk_pfn), 32'(lk_vpn));
      chk(req, "passthru prot", 32'(lk_prot), 32'd0);
    end else begin
      k = key_of(lk_super, lk_vpn);
      if (mdl.exists(k)) begin
        chk(req, "hit", 32'(lk_hit), 32'd1);
        chk(req, "pfn", 32'(lk_pfn), 32'(mdl[k][19:0]));
        chk(req, "prot", 32'(lk_prot), 32'(mdl[k][21:20]));
      end else begin
        chk(req, "miss", 32'(lk_hit), 32'd0);
      end
    end
    if (reg_rd) chk(req, "rdata", reg_rdata, exp_rdata());
    chk(req, "ctl outs", {29'd0, copro_en, icache_en, ext_cache_en}, {29'd0, m_cs[6], m_cs[5], m_cs[2]});
    chk(req, "ptrs", {usr_ptr[15:0], sup_ptr[15:0]}, {m_uptr[15:0], m_sptr[15:0]});
  endtask

  task automatic drop_mode(input logic s);
    int q[$];
    foreach (mdl[k]) if (((k >> PN_W) & 1) == int'(s)) q.push_back(k);
    foreach (q[i]) mdl.delete(q[i]);
  endtask

  task automatic model_step();
    logic fu, fs;
    logic [15:0] setv, clrv, ctl;
    int q[$];
    fu = 0; fs = 0;
    if (reg_rd && reg_sel == 2'd2) begin fu = 1; fs = 1; end
    if (reg_wr) begin
      case (reg_sel)
        2'd0: begin m_sptr = reg_wdata[PN_W-1:0]; fs = 1; end
        2'd1: begin m_uptr = reg_wdata[PN_W-1:0]; fu = 1; end
        2'd2: begin
          if (reg_wdata == 32'h0) fu = 1;
          else if (reg_wdata == 32'h8000) fs = 1;
        end
        default: ;
      endcase
    end
    setv = {flt_ptab, flt_page, flt_prot, 9'd0, flt_bus, 3'd0};
    clrv = (reg_wr && reg_sel == 2'd3) ? (reg_wdata[15:0] & FMASK) : 16'd0;
    ctl  = (reg_wr && reg_sel == 2'd3) ? (reg_wdata[15:0] & CMASK) : (m_cs & CMASK);
    m_cs = ctl | (((m_cs & FMASK) & ~clrv) | setv);
    if (rf_valid && !(rf_super ? fs : fu) && !(pg_valid && pg_vpn == rf_vpn)) begin
      foreach (mdl[k])
        if (((k >> PN_W) & 1) == int'(rf_super) && (k % DEPTH) == (int'(rf_vpn) % DEPTH))
          q.push_back(k);
      foreach (q[i]) mdl.delete(q[i]);
      mdl[key_of(rf_super, rf_vpn)] = {rf_prot, rf_pfn};
    end
    if (pg_valid) begin
      if (mdl.exists(key_of(1'b0, pg_vpn))) mdl.delete(key_of(1'b0, pg_vpn));
      if (mdl.exists(key_of(1'b1, pg_vpn))) mdl.delete(key_of(1'b1, pg_vpn));
    end
    if (fu) drop_mode(1'b0);
    if (fs) drop_mode(1'b1);
  endtask

  // inputs set after a falling edge; check, clock, update model, release strobes
  task automatic tick(input string req);
    #1;
    compare(req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    rf_valid = 0; pg_valid = 0; reg_wr = 0; reg_rd = 0;
    flt_ptab = 0; flt_page = 0; flt_prot = 0; flt_bus = 0;
  endtask

  task automatic look(input logic s, input int vpn, input string req);
    lk_super = s; lk_vpn = PN_W'(vpn);
    tick(req);
  endtask

  task automatic set_fill(input logic s, input int vpn, input int pfn, input logic [1:0] p);
    rf_valid = 1; rf_super = s; rf_vpn = PN_W'(vpn); rf_pfn = PN_W'(pfn); rf_prot = p;
  endtask

  task automatic fill(input logic s, input int vpn, input int pfn, input logic [1:0] p, input string req);
    set_fill(s, vpn, pfn, p);
    tick(req);
  endtask

  task automatic set_wr(input logic [1:0] sel, input logic [31:0] d);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input string req);
    set_wr(sel, d);
    tick(req);
  endtask

  task automatic rd(input logic [1:0] sel, input string req);
    reg_rd = 1; reg_sel = sel;
    tick(req);
  endtask

  task automatic look_both(input int vpn, input string req);
    look(1'b0, vpn, req);
    look(1'b1, vpn, req);
  endtask

  task automatic load_set(input string req);
    for (int i = 0; i < 4; i++) begin
      fill(1'b0, 'h100 + i, 'hA0000 + i, 2'(i), req);
      fill(1'b1, 'h200 + i, 'hB0000 + i, 2'(3 - i), req);
    end
  endtask

  logic done = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state, translation disabled
    rd(2'd3, "R11");
    rd(2'd0, "R11");
    rd(2'd1, "R11");
    look_both('h123, "R11");
    // enable both modes
    wr(2'd3, 32'h0000_0003, "R8");
    look_both('h012, "R11");
    // R2 / R1 basic refill and isolation
    fill(1'b0, 'h012, 'hABCDE, 2'b01, "R2");
    look_both('h012, "R1");
    fill(1'b1, 'h012, 'h11111, 2'b10, "R1");
    look_both('h012, "R1");
    // R2 replacement at the same slot
    fill(1'b0, 'h022, 'h33333, 2'b11, "R2");
    look_both('h012, "R2");
    look(1'b0, 'h022, "R2");
    load_set("R2");
    for (int i = 0; i < 4; i++) begin
      look(1'b0, 'h100 + i, "R2");
      look(1'b1, 'h200 + i, "R2");
    end
    // R4 unrelated code value does nothing
    wr(2'd2, 32'h0000_1234, "R4");
    look(1'b0, 'h101, "R4");
    look(1'b1, 'h201, "R4");
    wr(2'd2, 32'h0000_0000, "R4");
    look(1'b0, 'h101, "R4");
    look(1'b1, 'h201, "R4");
    load_set("R4");
    wr(2'd2, 32'h0000_8000, "R4");
    look(1'b0, 'h102, "R4");
    look(1'b1, 'h202, "R4");
    // R3 read of flush register
    load_set("R3");
    rd(2'd2, "R3");
    look(1'b0, 'h103, "R3");
    look(1'b1, 'h203, "R3");
    // R5 pointer writes
    load_set("R5");
    wr(2'd1, 32'hFFF5_A5A5, "R5");
    rd(2'd1, "R5");
    look(1'b0, 'h100, "R5");
    look(1'b1, 'h200, "R5");
    wr(2'd0, 32'h0001_2345, "R5");
    rd(2'd0, "R5");
    look(1'b1, 'h200, "R5");
    // R6 purge
    fill(1'b0, 'h300, 'h44444, 2'b00, "R6");
    fill(1'b1, 'h300, 'h55555, 2'b01, "R6");
    fill(1'b0, 'h301, 'h66666, 2'b10, "R6");
    pg_valid = 1; pg_vpn = 'h310;
    tick("R6");
    look_both('h300, "R6");
    pg_valid = 1; pg_vpn = 'h300;
    tick("R6");
    look_both('h300, "R6");
    look(1'b0, 'h301, "R6");
    // R7 sticky faults
    flt_page = 1;
    tick("R7");
    rd(2'd3, "R7");
    wr(2'd3, 32'h0000_0003, "R7");
    rd(2'd3, "R7");
    wr(2'd3, 32'h0000_4003, "R7");
    rd(2'd3, "R7");
    flt_ptab = 1; flt_bus = 1;
    set_wr(2'd3, 32'h0000_8003);
    tick("R7");
    rd(2'd3, "R7");
    flt_prot = 1;
    tick("R7");
    wr(2'd3, 32'h0000_E00B, "R7");
    rd(2'd3, "R7");
    // R9 control outputs
    wr(2'd3, 32'h0000_0067, "R9");
    rd(2'd3, "R9");
    wr(2'd3, 32'h0000_0023, "R9");
    rd(2'd3, "R9");
    wr(2'd3, 32'h0000_0003, "R9");
    // R10 invalidation wins over refill
    set_fill(1'b0, 'h400, 'h77777, 2'b01);
    set_wr(2'd2, 32'h0);
    tick("R10");
    look(1'b0, 'h400, "R10");
    set_fill(1'b1, 'h401, 'h77778, 2'b01);
    reg_rd = 1; reg_sel = 2'd2;
    tick("R10");
    look(1'b1, 'h401, "R10");
    set_fill(1'b0, 'h410, 'h88888, 2'b10);
    pg_valid = 1; pg_vpn = 'h410;
    tick("R10");
    look(1'b0, 'h410, "R10");
    fill(1'b0, 'h430, 'h99998, 2'b00, "R10");
    set_fill(1'b0, 'h420, 'h99999, 2'b11);
    pg_valid = 1; pg_vpn = 'h430;
    tick("R10");
    look(1'b0, 'h420, "R10");
    look(1'b0, 'h430, "R10");
    set_fill(1'b1, 'h440, 'h12121, 2'b01);
    set_wr(2'd0, 32'h0000_0777);
    tick("R10");
    look(1'b1, 'h440, "R10");
    set_fill(1'b0, 'h450, 'h13131, 2'b01);
    set_wr(2'd0, 32'h0000_0778);
    tick("R10");
    look(1'b0, 'h450, "R10");
    // R8 one mode disabled
    fill(1'b1, 'h460, 'h14141, 2'b10, "R8");
    wr(2'd3, 32'h0000_0001, "R8");
    look(1'b1, 'h460, "R8");
    look(1'b0, 'h450, "R8");
    wr(2'd3, 32'h0000_0003, "R8");
    look(1'b1, 'h460, "R8");
    wr(2'd3, 32'h0000_0000, "R8");
    look_both('hFFFFF, "R8");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule